// File: doc/BRIEF.md
# System Control Register File

This block holds the privileged control registers of a processor core and gives the pipeline one port to reach them. The access port carries a 5-bit register number, a 3-bit select, 32 bits of write data and a write strobe. The read data is a combinational function of the addressed register. Each register applies its own rule to a write: some bits come from the data, some keep their old value, and the rest read as zero.

Beside the register storage, the block drives the core's mode flags: user mode, exception level, error level and debug mode. It produces a one-cycle interrupt-raise pulse, together with a level that stays high while a hard interrupt is held pending. When a write changes the address-space ID, it emits a one-cycle flush pulse, so that cached translations can be dropped. It also keeps a free-running cycle counter and a comparator that raises a timer interrupt.

The pipeline decodes a move-to or move-from instruction and presents it on the port. Writes commit on the clock edge; reads are returned in the same cycle.

Top module: `sysctl_regfile`

## Requirements
- R1: A non-zero select is accepted only for register numbers 16 and 28. Any other non-zero select raises `bad_access` in that cycle, reads 0 and leaves every register unchanged. Register 16 select 1 and register 28 select 1 are valid.
- R2: A write to register 0 (slot index) takes only data bits 3:0, and bit 31 is left unchanged. Registers 2 and 3 (page entry low words) store the data AND 0x3FFFFFFF. Register 5 (page size mask) stores the data AND 0x01FFE000. Register 6 (fixed-entry count) stores only bits 3:0.
- R3: Register 4 (table pointer) keeps bits 31:24 and takes bits 23:4 from the data. Register 19 (watch high) stores the data AND 0x40FF0FF8. Register 28 select 0 (cache tag) stores the data AND 0xFFFFFCF6.
- R4: Register 10 (page entry high) stores the data AND 0xFFFFF0FF. When data bits 7:0 differ from the stored address-space ID, `asid_flush` is high for exactly the one cycle after the write edge; otherwise it stays low.
- R5: Register 12 (status) stores the data AND 0xFA78FF01. Data bits 4, 2 and 1 set `mode_user`, `mode_erl` and `mode_exl`, and a read of register 12 returns those flags in the same bit positions.
- R6: A status write pulses `irq_raise` for one cycle and sets `irq_pending` only if all of these hold: bit 0 goes from 0 to 1; the written bits 1 and 2 and the debug flag are all clear; and (new status AND cause AND 0x0000FF00) is non-zero.
- R7: A status write that changes bit 0 from 1 to 0 clears `irq_pending`.
- R8: Register 13 (cause) keeps the bits in 0xB000F87C and takes only the bits in 0x00C00300 from the data. A write that sets a software-interrupt bit (bit 8 or 9) that was clear pulses `irq_raise` and sets `irq_pending`.
- R9: Register 23 (debug) keeps the bits in 0x8C03FC1F and takes the bits in 0x13300120 from the data. Data bit 30 sets `mode_debug`, and a read of register 23 returns that flag in bit 30.
- R10: A read of register 17 (linked address) returns the stored value shifted right by 4. Register 16 selects 0 and 1 return the constants `CONFIG0_VAL` and `CONFIG1_VAL`. Register 28 select 1 is a full-width data word, kept apart from the tag at select 0.
- R11: Register 9 (counter) increases by one on every clock. A write loads it with the data, and counting continues from that value.
- R12: The cycle after the counter equals register 11 (compare), `timer_irq` goes high and stays high. A write to register 11 clears it. While high, it reads as cause bit 15.
- R13: After reset, all registers and outputs read 0, except compare, which reads `COMPARE_RST` (all ones by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_reg | input | 5 | Register number |
| cp_sel | input | 3 | Register select |
| cp_wr | input | 1 | Write strobe |
| cp_wdata | input | 32 | Write data |
| cp_rdata | output | 32 | Read data for the addressed register |
| bad_access | output | 1 | Illegal register/select combination |
| mode_user | output | 1 | User-mode flag |
| mode_exl | output | 1 | Exception-level flag |
| mode_erl | output | 1 | Error-level flag |
| mode_debug | output | 1 | Debug-mode flag |
| irq_raise | output | 1 | One-cycle interrupt-raise pulse |
| irq_pending | output | 1 | Hard interrupt held pending |
| asid_flush | output | 1 | One-cycle translation flush pulse |
| timer_irq | output | 1 | Timer interrupt level |

## Verification
Some properties are checked on every cycle. An illegal access never alters status, cause or page entry high. A flush or raise pulse only follows a write. Pending only rises together with a raise pulse. The counter steps by one unless it is written, and a compare write always clears the timer. The status and debug read-backs always agree with the mode flags. The bench scenarios cover the rest: the exact mask values, the full raise condition (including the cases blocked by exception level and debug mode), edge-only raising from software bits, and the exact cycle in which the timer fires.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int WORD_W = 32;
   localparam int ASID_W = 8;

   typedef enum logic [4:0] {
      RID_NONE, RID_INDEX, RID_ELO0, RID_ELO1, RID_CTX, RID_PMASK, RID_WIRED,
      RID_COUNT, RID_EHI, RID_CMP, RID_STATUS, RID_CAUSE, RID_EPC, RID_CFG0,
      RID_CFG1, RID_LLA, RID_WLO, RID_WHI, RID_DBG, RID_DEPC, RID_TAG,
      RID_DATA, RID_EEPC, RID_DSAVE
   } reg_id_e;

   localparam logic [WORD_W-1:0] M_IDX_KEEP = 32'h8000_0000;
   localparam logic [WORD_W-1:0] M_IDX_TAKE = 32'h0000_000F;
   localparam logic [WORD_W-1:0] M_ELO      = 32'h3FFF_FFFF;
   localparam logic [WORD_W-1:0] M_PMASK    = 32'h01FF_E000;
   localparam logic [WORD_W-1:0] M_WIRED    = 32'h0000_000F;
   localparam logic [WORD_W-1:0] M_CTX_KEEP = 32'hFF00_0000;
   localparam logic [WORD_W-1:0] M_CTX_TAKE = 32'h00FF_FFF0;
   localparam logic [WORD_W-1:0] M_EHI      = 32'hFFFF_F0FF;
   localparam logic [WORD_W-1:0] M_STATUS   = 32'hFA78_FF01;
   localparam logic [WORD_W-1:0] M_CA_KEEP  = 32'hB000_F87C;
   localparam logic [WORD_W-1:0] M_CA_TAKE  = 32'h00C0_0300;
   localparam logic [WORD_W-1:0] M_WHI      = 32'h40FF_0FF8;
   localparam logic [WORD_W-1:0] M_TAG      = 32'hFFFF_FCF6;
   localparam logic [WORD_W-1:0] M_DB_KEEP  = 32'h8C03_FC1F;
   localparam logic [WORD_W-1:0] M_DB_TAKE  = 32'h1330_0120;
   localparam logic [WORD_W-1:0] M_IRQ      = 32'h0000_FF00;

   localparam int B_IE   = 0;
   localparam int B_EXL  = 1;
   localparam int B_ERL  = 2;
   localparam int B_UM   = 4;
   localparam int B_DM   = 30;
   localparam int B_TIMR = 15;
   localparam int B_SW0  = 8;
   localparam int LLA_SH = 4;

   localparam int N_PLAIN = 7;

   function automatic logic [WORD_W-1:0] merge_bits(
      input logic [WORD_W-1:0] old_v,
      input logic [WORD_W-1:0] new_v,
      input logic [WORD_W-1:0] keep_m,
      input logic [WORD_W-1:0] take_m);
      return (old_v & keep_m) | (new_v & take_m);
   endfunction

   function automatic reg_id_e plain_id(input int slot);
      case (slot)
         0:       return RID_EPC;
         1:       return RID_LLA;
         2:       return RID_WLO;
         3:       return RID_DEPC;
         4:       return RID_DATA;
         5:       return RID_EEPC;
         default: return RID_DSAVE;
      endcase
   endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int NUM_W = 5,
   parameter int SEL_W = 3
) (
   input  logic [NUM_W-1:0] num,
   input  logic [SEL_W-1:0] sel,
   output reg_id_e          rid,
   output logic             bad
);

   generate
      if (NUM_W != 5 || SEL_W != 3) begin : g_bad_cfg
         $error("sysctl_decode: register number must be 5 bits and select 3 bits");
      end
   endgenerate

   logic multi_sel_ok;
   assign multi_sel_ok = (num == 5'd16) || (num == 5'd28);

   always_comb begin
      bad = (sel != '0) && !multi_sel_ok;
      rid = RID_NONE;
      if (!bad) begin
         case (num)
            5'd0:  rid = RID_INDEX;
            5'd2:  rid = RID_ELO0;
            5'd3:  rid = RID_ELO1;
            5'd4:  rid = RID_CTX;
            5'd5:  rid = RID_PMASK;
            5'd6:  rid = RID_WIRED;
            5'd9:  rid = RID_COUNT;
            5'd10: rid = RID_EHI;
            5'd11: rid = RID_CMP;
            5'd12: rid = RID_STATUS;
            5'd13: rid = RID_CAUSE;
            5'd14: rid = RID_EPC;
            5'd16: rid = (sel == 3'd0) ? RID_CFG0 : (sel == 3'd1) ? RID_CFG1 : RID_NONE;
            5'd17: rid = RID_LLA;
            5'd18: rid = RID_WLO;
            5'd19: rid = RID_WHI;
            5'd23: rid = RID_DBG;
            5'd24: rid = RID_DEPC;
            5'd28: rid = (sel == 3'd0) ? RID_TAG : (sel == 3'd1) ? RID_DATA : RID_NONE;
            5'd30: rid = RID_EEPC;
            5'd31: rid = RID_DSAVE;
            default: rid = RID_NONE;
         endcase
      end
   end

endmodule

// File: rtl/sysctl_timer.sv
module sysctl_timer #(
   parameter int             DW       = 32,
   parameter bit             TIMER_EN = 1'b1,
   parameter logic [DW-1:0]  CMP_RST  = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_count,
   input  logic          we_cmp,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] count,
   output logic [DW-1:0] compare,
   output logic          timer_irq
);

   generate
      if (DW < 8) begin : g_bad_cfg
         $error("sysctl_timer: counter narrower than 8 bits");
      end

      if (TIMER_EN) begin : g_on
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               count     <= '0;
               compare   <= CMP_RST;
               timer_irq <= 1'b0;
            end else begin
               count <= we_count ? wdata : count + DW'(1);
               if (we_cmp) begin
                  compare   <= wdata;
                  timer_irq <= 1'b0;
               end else if (count == compare) begin
                  timer_irq <= 1'b1;
               end
            end
         end

         assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !we_count |=> count == $past(count) + DW'(1));

         assert_cmp_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
            we_cmp |=> !timer_irq);
      end else begin : g_off
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               count   <= '0;
               compare <= CMP_RST;
            end else begin
               if (we_count) count   <= wdata;
               if (we_cmp)   compare <= wdata;
            end
         end
         assign timer_irq = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sysctl_irq.sv
module sysctl_irq #(
   parameter int             DW    = 32,
   parameter logic [DW-1:0]  IMASK = 32'h0000_FF00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_we,
   input  logic          old_ie,
   input  logic [DW-1:0] new_st,
   input  logic          blocked,
   input  logic [DW-1:0] cause_eff,
   input  logic          ca_we,
   input  logic [1:0]    old_sw,
   input  logic [1:0]    new_sw,
   output logic          raise,
   output logic          pending
);

   generate
      if (DW < 16) begin : g_bad_cfg
         $error("sysctl_irq: word too narrow for the interrupt mask");
      end
   endgenerate

   logic unmask_hit, sw_hit, ie_drop, raise_c;

   assign unmask_hit = st_we && new_st[0] && !old_ie && !blocked &&
                       ((new_st & cause_eff & IMASK) != '0);
   assign sw_hit     = ca_we && ((new_sw & ~old_sw) != 2'b00);
   assign ie_drop    = st_we && !new_st[0] && old_ie;
   assign raise_c    = unmask_hit || sw_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raise   <= 1'b0;
         pending <= 1'b0;
      end else begin
         raise <= raise_c;
         if (raise_c)      pending <= 1'b1;
         else if (ie_drop) pending <= 1'b0;
      end
   end

   assert_raise_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      raise |-> $past(st_we || ca_we));

   assert_pending_needs_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> raise);

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
   import sysctl_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter bit          TIMER_EN    = 1'b1,
   parameter logic [31:0] COMPARE_RST = 32'hFFFF_FFFF,
   parameter logic [31:0] CONFIG0_VAL = 32'h8000_8082,
   parameter logic [31:0] CONFIG1_VAL = 32'h1E19_0C8A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        cp_reg,
   input  logic [2:0]        cp_sel,
   input  logic              cp_wr,
   input  logic [DATA_W-1:0] cp_wdata,
   output logic [DATA_W-1:0] cp_rdata,
   output logic              bad_access,
   output logic              mode_user,
   output logic              mode_exl,
   output logic              mode_erl,
   output logic              mode_debug,
   output logic              irq_raise,
   output logic              irq_pending,
   output logic              asid_flush,
   output logic              timer_irq
);

   generate
      if (DATA_W != WORD_W) begin : g_bad_cfg
         $error("sysctl_regfile: data width must match the 32-bit register masks");
      end
   endgenerate

   reg_id_e rid;
   logic    bad;

   sysctl_decode #(.NUM_W(5), .SEL_W(3)) u_dec (
      .num (cp_reg),
      .sel (cp_sel),
      .rid (rid),
      .bad (bad)
   );
   assign bad_access = bad;

   logic [DATA_W-1:0] wd;
   assign wd = cp_wdata;

   function automatic logic hit(input reg_id_e cur, input reg_id_e want, input logic wr);
      return wr && (cur == want);
   endfunction

   logic we_status, we_cause, we_ehi, we_dbg;
   assign we_status = hit(rid, RID_STATUS, cp_wr);
   assign we_cause  = hit(rid, RID_CAUSE,  cp_wr);
   assign we_ehi    = hit(rid, RID_EHI,    cp_wr);
   assign we_dbg    = hit(rid, RID_DBG,    cp_wr);

   logic [DATA_W-1:0] index_q, elo0_q, elo1_q, ctx_q, pmask_q, wired_q;
   logic [DATA_W-1:0] ehi_q, status_q, cause_q, whi_q, dbg_q, tag_q;
   logic              um_q, exl_q, erl_q, dm_q, flush_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q  <= '0;
         elo0_q   <= '0;
         elo1_q   <= '0;
         ctx_q    <= '0;
         pmask_q  <= '0;
         wired_q  <= '0;
         ehi_q    <= '0;
         whi_q    <= '0;
         tag_q    <= '0;
         flush_q  <= 1'b0;
      end else begin
         if (hit(rid, RID_INDEX, cp_wr)) index_q <= merge_bits(index_q, wd, M_IDX_KEEP, M_IDX_TAKE);
         if (hit(rid, RID_ELO0,  cp_wr)) elo0_q  <= wd & M_ELO;
         if (hit(rid, RID_ELO1,  cp_wr)) elo1_q  <= wd & M_ELO;
         if (hit(rid, RID_CTX,   cp_wr)) ctx_q   <= merge_bits(ctx_q, wd, M_CTX_KEEP, M_CTX_TAKE);
         if (hit(rid, RID_PMASK, cp_wr)) pmask_q <= wd & M_PMASK;
         if (hit(rid, RID_WIRED, cp_wr)) wired_q <= wd & M_WIRED;
         if (hit(rid, RID_WHI,   cp_wr)) whi_q   <= wd & M_WHI;
         if (hit(rid, RID_TAG,   cp_wr)) tag_q   <= wd & M_TAG;
         if (we_ehi)                     ehi_q   <= wd & M_EHI;
         flush_q <= we_ehi && (ehi_q[ASID_W-1:0] != wd[ASID_W-1:0]);
      end
   end
   assign asid_flush = flush_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         cause_q  <= '0;
         dbg_q    <= '0;
         um_q     <= 1'b0;
         exl_q    <= 1'b0;
         erl_q    <= 1'b0;
         dm_q     <= 1'b0;
      end else begin
         if (we_status) begin
            status_q <= wd & M_STATUS;
            um_q     <= wd[B_UM];
            exl_q    <= wd[B_EXL];
            erl_q    <= wd[B_ERL];
         end
         if (we_cause) cause_q <= merge_bits(cause_q, wd, M_CA_KEEP, M_CA_TAKE);
         if (we_dbg) begin
            dbg_q <= merge_bits(dbg_q, wd, M_DB_KEEP, M_DB_TAKE);
            dm_q  <= wd[B_DM];
         end
      end
   end
   assign mode_user  = um_q;
   assign mode_exl   = exl_q;
   assign mode_erl   = erl_q;
   assign mode_debug = dm_q;

   logic [DATA_W-1:0] plain_q [N_PLAIN];
   generate
      for (genvar gi = 0; gi < N_PLAIN; gi++) begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          plain_q[gi] <= '0;
            else if (hit(rid, plain_id(gi), cp_wr)) plain_q[gi] <= wd;
         end
      end
   endgenerate

   logic [DATA_W-1:0] count_v, compare_v;

   sysctl_timer #(.DW(DATA_W), .TIMER_EN(TIMER_EN), .CMP_RST(COMPARE_RST)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_count  (hit(rid, RID_COUNT, cp_wr)),
      .we_cmp    (hit(rid, RID_CMP, cp_wr)),
      .wdata     (wd),
      .count     (count_v),
      .compare   (compare_v),
      .timer_irq (timer_irq)
   );

   logic [DATA_W-1:0] cause_eff, status_rd, new_status;
   assign cause_eff  = cause_q | (DATA_W'(timer_irq) << B_TIMR);
   assign status_rd  = status_q | (DATA_W'(um_q) << B_UM) | (DATA_W'(erl_q) << B_ERL) |
                       (DATA_W'(exl_q) << B_EXL);
   assign new_status = wd & M_STATUS;

   sysctl_irq #(.DW(DATA_W), .IMASK(M_IRQ)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_we     (we_status),
      .old_ie    (status_q[B_IE]),
      .new_st    (new_status),
      .blocked   (wd[B_EXL] || wd[B_ERL] || dm_q),
      .cause_eff (cause_eff),
      .ca_we     (we_cause),
      .old_sw    (cause_q[B_SW0+1:B_SW0]),
      .new_sw    (wd[B_SW0+1:B_SW0]),
      .raise     (irq_raise),
      .pending   (irq_pending)
   );

   always_comb begin
      case (rid)
         RID_INDEX:  cp_rdata = index_q;
         RID_ELO0:   cp_rdata = elo0_q;
         RID_ELO1:   cp_rdata = elo1_q;
         RID_CTX:    cp_rdata = ctx_q;
         RID_PMASK:  cp_rdata = pmask_q;
         RID_WIRED:  cp_rdata = wired_q;
         RID_COUNT:  cp_rdata = count_v;
         RID_EHI:    cp_rdata = ehi_q;
         RID_CMP:    cp_rdata = compare_v;
         RID_STATUS: cp_rdata = status_rd;
         RID_CAUSE:  cp_rdata = cause_eff;
         RID_EPC:    cp_rdata = plain_q[0];
         RID_CFG0:   cp_rdata = CONFIG0_VAL;
         RID_CFG1:   cp_rdata = CONFIG1_VAL;
         RID_LLA:    cp_rdata = plain_q[1] >> LLA_SH;
         RID_WLO:    cp_rdata = plain_q[2];
         RID_WHI:    cp_rdata = whi_q;
         RID_DBG:    cp_rdata = dbg_q | (DATA_W'(dm_q) << B_DM);
         RID_DEPC:   cp_rdata = plain_q[3];
         RID_TAG:    cp_rdata = tag_q;
         RID_DATA:   cp_rdata = plain_q[4];
         RID_EEPC:   cp_rdata = plain_q[5];
         RID_DSAVE:  cp_rdata = plain_q[6];
         default:    cp_rdata = '0;
      endcase
   end

   assert_bad_write_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_wr && bad_access) |=> $stable(status_q) && $stable(cause_q) && $stable(ehi_q));

   assert_flush_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      asid_flush |-> $past(we_ehi));

   assert_status_um_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_reg == 5'd12 && cp_sel == 3'd0) |-> cp_rdata[B_UM] == mode_user);

   assert_debug_dm_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_reg == 5'd23 && cp_sel == 3'd0) |-> cp_rdata[B_DM] == mode_debug);

endmodule

// File: tb/tb_sysctl_regfile.sv
`timescale 1ns/1ps
module tb_sysctl_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cp_reg = '0;
   logic [2:0]  cp_sel = '0;
   logic        cp_wr = 1'b0;
   logic [31:0] cp_wdata = '0;
   logic [31:0] cp_rdata;
   logic        bad_access, mode_user, mode_exl, mode_erl, mode_debug;
   logic        irq_raise, irq_pending, asid_flush, timer_irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   sysctl_regfile dut (
      .clk(clk), .rst_n(rst_n), .cp_reg(cp_reg), .cp_sel(cp_sel), .cp_wr(cp_wr),
      .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .bad_access(bad_access),
      .mode_user(mode_user), .mode_exl(mode_exl), .mode_erl(mode_erl),
      .mode_debug(mode_debug), .irq_raise(irq_raise), .irq_pending(irq_pending),
      .asid_flush(asid_flush), .timer_irq(timer_irq)
   );

   task automatic chk(input string req, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] r, input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      cp_reg = r; cp_sel = s; cp_wdata = d; cp_wr = 1'b1;
      @(posedge clk);
      #1 cp_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] r, input logic [2:0] s, output logic [31:0] d);
      @(negedge clk);
      cp_reg = r; cp_sel = s; cp_wr = 1'b0;
      #1 d = cp_rdata;
   endtask

   task automatic next_sample;
      @(negedge clk);
      #1;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(5'd12, 3'd0, v); chk("R13", "status", v, 32'h0);
      rd(5'd13, 3'd0, v); chk("R13", "cause", v, 32'h0);
      rd(5'd0,  3'd0, v); chk("R13", "index", v, 32'h0);
      rd(5'd11, 3'd0, v); chk("R13", "compare", v, 32'hFFFF_FFFF);
      chk("R13", "flags", {mode_user, mode_exl, mode_erl, mode_debug}, 32'h0);
      chk("R13", "irq outs", {irq_raise, irq_pending, asid_flush, timer_irq}, 32'h0);
   endtask

   task automatic t_masks;
      logic [31:0] v;
      wr(5'd0, 3'd0, 32'hFFFF_FFFF); rd(5'd0, 3'd0, v); chk("R2", "index", v, 32'h0000_000F);
      wr(5'd2, 3'd0, 32'hFFFF_FFFF); rd(5'd2, 3'd0, v); chk("R2", "entry lo0", v, 32'h3FFF_FFFF);
      wr(5'd3, 3'd0, 32'hC000_0001); rd(5'd3, 3'd0, v); chk("R2", "entry lo1", v, 32'h0000_0001);
      wr(5'd5, 3'd0, 32'hFFFF_FFFF); rd(5'd5, 3'd0, v); chk("R2", "page mask", v, 32'h01FF_E000);
      wr(5'd6, 3'd0, 32'h0000_00FF); rd(5'd6, 3'd0, v); chk("R2", "wired", v, 32'h0000_000F);
      wr(5'd4, 3'd0, 32'hFFFF_FFFF); rd(5'd4, 3'd0, v); chk("R3", "context", v, 32'h00FF_FFF0);
      wr(5'd19, 3'd0, 32'hFFFF_FFFF); rd(5'd19, 3'd0, v); chk("R3", "watch hi", v, 32'h40FF_0FF8);
      wr(5'd28, 3'd0, 32'hFFFF_FFFF); rd(5'd28, 3'd0, v); chk("R3", "tag", v, 32'hFFFF_FCF6);
   endtask

   task automatic t_bad;
      logic [31:0] v;
      wr(5'd12, 3'd2, 32'h0000_0017);
      rd(5'd12, 3'd3, v);
      chk("R1", "bad flag", {31'b0, bad_access}, 32'h1);
      chk("R1", "bad read", v, 32'h0);
      rd(5'd12, 3'd0, v); chk("R1", "status untouched", v, 32'h0);
      chk("R1", "flags untouched", {mode_user, mode_exl, mode_erl}, 32'h0);
      rd(5'd16, 3'd1, v); chk("R1", "sel1 on 16 legal", {31'b0, bad_access}, 32'h0);
   endtask

   task automatic t_entryhi;
      logic [31:0] v;
      wr(5'd10, 3'd0, 32'hFFFF_FFFF);
      next_sample; chk("R4", "flush on asid change", {31'b0, asid_flush}, 32'h1);
      next_sample; chk("R4", "flush one cycle", {31'b0, asid_flush}, 32'h0);
      rd(5'd10, 3'd0, v); chk("R4", "entry hi", v, 32'hFFFF_F0FF);
      wr(5'd10, 3'd0, 32'h0123_45FF);
      next_sample; chk("R4", "no flush same asid", {31'b0, asid_flush}, 32'h0);
      rd(5'd10, 3'd0, v); chk("R4", "entry hi 2", v, 32'h0123_40FF);
   endtask

   task automatic t_status;
      logic [31:0] v;
      wr(5'd12, 3'd0, 32'h0000_0016);
      rd(5'd12, 3'd0, v); chk("R5", "status flags read", v, 32'h0000_0016);
      chk("R5", "mode flags", {mode_user, mode_exl, mode_erl}, 32'h7);
      wr(5'd12, 3'd0, 32'hFFFF_FFFF);
      next_sample; chk("R6", "no raise under exl", {31'b0, irq_raise}, 32'h0);
      rd(5'd12, 3'd0, v); chk("R5", "status mask", v, 32'hFA78_FF17);
      wr(5'd12, 3'd0, 32'h0);
      rd(5'd12, 3'd0, v); chk("R5", "status clear", v, 32'h0);
      chk("R5", "flags clear", {mode_user, mode_exl, mode_erl}, 32'h0);
   endtask

   task automatic t_irq;
      logic [31:0] v;
      wr(5'd13, 3'd0, 32'h0000_0100);
      next_sample; chk("R8", "sw bit raise", {irq_raise, irq_pending}, 32'h3);
      wr(5'd12, 3'd0, 32'h0000_0001);
      next_sample; chk("R6", "no raise without mask", {31'b0, irq_raise}, 32'h0);
      wr(5'd12, 3'd0, 32'h0);
      next_sample; chk("R7", "ie drop clears pending", {31'b0, irq_pending}, 32'h0);
      wr(5'd12, 3'd0, 32'h0000_0101);
      next_sample; chk("R6", "unmask raise", {irq_raise, irq_pending}, 32'h3);
      next_sample; chk("R6", "raise one cycle", {31'b0, irq_raise}, 32'h0);
      wr(5'd12, 3'd0, 32'h0000_0100);
      next_sample; chk("R7", "ie drop 2", {31'b0, irq_pending}, 32'h0);
      wr(5'd12, 3'd0, 32'h0000_0103);
      next_sample; chk("R6", "blocked by exl", {irq_raise, irq_pending}, 32'h0);
      wr(5'd12, 3'd0, 32'h0);
      wr(5'd13, 3'd0, 32'h0000_0100);
      next_sample; chk("R8", "already set no raise", {31'b0, irq_raise}, 32'h0);
      wr(5'd13, 3'd0, 32'hFFFF_FFFF);
      next_sample; chk("R8", "new sw bit raise", {31'b0, irq_raise}, 32'h1);
      rd(5'd13, 3'd0, v); chk("R8", "cause mask", v, 32'h00C0_0300);
      wr(5'd13, 3'd0, 32'h0);
      rd(5'd13, 3'd0, v); chk("R8", "cause clear", v, 32'h0);
   endtask

   task automatic t_debug;
      logic [31:0] v;
      wr(5'd23, 3'd0, 32'hFFFF_FFFF);
      rd(5'd23, 3'd0, v); chk("R9", "debug read", v, 32'h5330_0120);
      chk("R9", "debug flag", {31'b0, mode_debug}, 32'h1);
      wr(5'd13, 3'd0, 32'h0000_0100);
      wr(5'd12, 3'd0, 32'h0000_0101);
      next_sample; chk("R6", "blocked by debug", {31'b0, irq_raise}, 32'h0);
      wr(5'd23, 3'd0, 32'h0);
      rd(5'd23, 3'd0, v); chk("R9", "debug cleared", v, 32'h0);
      chk("R9", "debug flag off", {31'b0, mode_debug}, 32'h0);
      wr(5'd12, 3'd0, 32'h0);
   endtask

   task automatic t_misc;
      logic [31:0] v;
      wr(5'd17, 3'd0, 32'h1234_5678);
      rd(5'd17, 3'd0, v); chk("R10", "linked addr shift", v, 32'h0123_4567);
      rd(5'd16, 3'd0, v); chk("R10", "config0", v, 32'h8000_8082);
      rd(5'd16, 3'd1, v); chk("R10", "config1", v, 32'h1E19_0C8A);
      wr(5'd28, 3'd1, 32'hA5A5_A5A5);
      rd(5'd28, 3'd1, v); chk("R10", "data word", v, 32'hA5A5_A5A5);
      rd(5'd28, 3'd0, v); chk("R10", "tag kept", v, 32'hFFFF_FCF6);
   endtask

   task automatic t_count;
      logic [31:0] v;
      wr(5'd9, 3'd0, 32'd1000);
      rd(5'd9, 3'd0, v); chk("R11", "count loaded", v, 32'd1000);
      repeat (4) @(negedge clk);
      rd(5'd9, 3'd0, v); chk("R11", "count steps", v, 32'd1005);
   endtask

   task automatic t_timer;
      logic [31:0] v;
      wr(5'd11, 3'd0, 32'd5000);
      wr(5'd9, 3'd0, 32'd4997);
      next_sample;
      repeat (3) @(negedge clk);
      #1 chk("R12", "timer before match", {31'b0, timer_irq}, 32'h0);
      next_sample; chk("R12", "timer fires", {31'b0, timer_irq}, 32'h1);
      rd(5'd13, 3'd0, v); chk("R12", "cause timer bit", {31'b0, v[15]}, 32'h1);
      wr(5'd11, 3'd0, 32'd5000);
      next_sample; chk("R12", "compare write clears", {31'b0, timer_irq}, 32'h0);
      next_sample; chk("R12", "stays clear", {31'b0, timer_irq}, 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset;
      t_masks;
      t_bad;
      t_entryhi;
      t_status;
      t_irq;
      t_debug;
      t_misc;
      t_count;
      t_timer;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule